// File: doc/BRIEF.md
# Operand Address Resolver with Constant Generator

This block turns one instruction operand specifier of a 16-bit register-based microcontroller core into everything the execution stage needs for that operand. It takes a 2-bit addressing mode, a register number, a byte/word flag, a snapshot of the register file and the extension word that follows the opcode. It returns one of three results: an effective address with a memory read request, an operand taken straight from a register, or a small immediate constant. Two special register numbers stand in for constants in certain modes, so common values need no extension word and no memory cycle.

The block also produces register update requests. It asks for a program-counter advance when an extension word is consumed, and for a post-increment write-back in auto-increment mode. It gives the address of the high byte of a little-endian word and flags effective addresses that fall in the peripheral window at the bottom of the address space. All results are registered and appear one clock after the request. The memory, the register storage and the ALU sit outside the block.

Top module: `opr_resolve`

## Requirements
- R1: While reset is asserted and on the first cycle after it, outValid, memRead, constValid, dataValid, pcWrEn, incWrEn and periphAccess are all 0.
- R2: Mode 0 (register) on register 3 gives constant 0 with no memory read. On any other register it gives dataValid=1 and dataOut equal to that register, masked to its low 8 bits when byteOp=1, with memRead=0 and constValid=0.
- R3: Mode 1 (indexed) on register 3 gives constant 1. On register 2 the effective address is extWord. On any other register it is that register plus extWord, modulo 2^16. memRead=1 in both address cases.
- R4: Mode 1 on any register other than 3 consumes the extension word: extAddr equals register 0 (the program counter), pcWrEn=1 and pcNext equals register 0 plus 2, modulo 2^16. No other case asserts pcWrEn.
- R5: Mode 2 (indirect) on register 2 gives constant 4 and on register 3 gives constant 2. On any other register the effective address is the register value, with memRead=1.
- R6: Mode 3 (auto-increment) on register 2 gives constant 8. On register 3 it gives all ones: 0x00FF in byte mode and 0xFFFF in word mode.
- R7: Mode 3 on a register other than 2 or 3 uses the pre-increment register value as the address and asserts incWrEn with incReg equal to that register. incValue is the register plus 1 when byteOp=1 and the register is not 0, and the register plus 2 otherwise (modulo 2^16).
- R8: periphAccess=1 exactly when memRead=1 and effAddr is below 0x0200.
- R9: Whenever memRead=1, hiAddr equals effAddr plus 1 modulo 2^16, so address 0xFFFF pairs with 0x0000.
- R10: Whenever a constant is produced, constValid=1, dataValid=1, dataOut holds the constant and memRead=0 in the same cycle. memRead and constValid are never 1 together.
- R11: Results appear on the clock edge after the one that samples reqValid=1, with outValid=1. A cycle with reqValid=0 produces outValid, memRead, constValid, dataValid, pcWrEn and incWrEn all 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operand resolve request |
| addrMode | input | 2 | Addressing mode: 0 register, 1 indexed, 2 indirect, 3 auto-increment |
| regSel | input | 4 | Register number: 0 PC, 1 SP, 2 status, 3 constant source |
| byteOp | input | 1 | 1 = byte operand, 0 = word operand |
| regFlat | input | 256 | Register file snapshot; register n at bits [16n+15:16n] |
| extWord | input | 16 | Extension word following the opcode |
| outValid | output | 1 | Results valid this cycle |
| effAddr | output | 16 | Effective address (low byte address) |
| hiAddr | output | 16 | Address of the high byte of the word |
| memRead | output | 1 | Operand must be read from memory |
| periphAccess | output | 1 | Effective address lies in the peripheral window |
| constValid | output | 1 | Operand is a generated constant |
| dataValid | output | 1 | dataOut holds the operand (constant or register) |
| dataOut | output | 16 | Operand value when dataValid=1 |
| extAddr | output | 16 | Address of the extension word |
| pcWrEn | output | 1 | Program counter advance request |
| pcNext | output | 16 | New program counter value |
| incWrEn | output | 1 | Post-increment write-back request |
| incReg | output | 4 | Register to receive the post-increment |
| incValue | output | 16 | Post-incremented register value |

## Verification
Every cycle, the assertions check the relations between outputs that must always hold. A constant and a memory read are never requested together. The peripheral flag agrees with the address. The high-byte address is always one above the low address. A consumed extension word always advances the program counter by two, and a post-increment always steps by one or two. An idle request produces no strobes on the next cycle. Only the bench can show which register or constant a given mode and register pair selects, the byte masking, and the choice between the program counter and other registers for the increment step, because it compares each result against values it computes itself.

// File: rtl/opr_pkg.sv
package opr_pkg;

  // Register numbers with fixed roles
  localparam int unsigned REG_PC = 0;
  localparam int unsigned REG_SP = 1;
  localparam int unsigned REG_SR = 2;
  localparam int unsigned REG_CG = 3;

  typedef enum logic [1:0] {
    AM_DIRECT  = 2'd0,
    AM_INDEXED = 2'd1,
    AM_INDIR   = 2'd2,
    AM_POSTINC = 2'd3
  } addrMode_e;

  typedef enum logic [2:0] {
    K_ZERO  = 3'd0,
    K_ONE   = 3'd1,
    K_TWO   = 3'd2,
    K_FOUR  = 3'd3,
    K_EIGHT = 3'd4,
    K_ONES  = 3'd5
  } constSel_e;

  // Strobes from decode control to datapath
  typedef struct packed {
    logic      active;
    logic      useConst;
    constSel_e constSel;
    logic      regDirect;
    logic      absAddr;
    logic      addExt;
    logic      regAddr;
    logic      fetchExt;
    logic      postInc;
    logic      incByOne;
    logic      byteMode;
  } oprStrobe_t;

endpackage

// File: rtl/opr_ctrl.sv
module opr_ctrl
  import opr_pkg::*;
#(
  parameter int unsigned REG_IDX_W = 4
) (
  input  logic                 reqValid,
  input  logic [1:0]           addrMode,
  input  logic [REG_IDX_W-1:0] regSel,
  input  logic                 byteOp,
  output oprStrobe_t           strobe
);

  localparam logic [REG_IDX_W-1:0] IDX_PC = REG_IDX_W'(REG_PC);
  localparam logic [REG_IDX_W-1:0] IDX_SR = REG_IDX_W'(REG_SR);
  localparam logic [REG_IDX_W-1:0] IDX_CG = REG_IDX_W'(REG_CG);

  logic isCg;
  logic isSr;
  logic isPc;

  assign isCg = (regSel == IDX_CG);
  assign isSr = (regSel == IDX_SR);
  assign isPc = (regSel == IDX_PC);

  always_comb begin
    strobe          = '0;
    strobe.constSel = K_ZERO;
    strobe.byteMode = byteOp;
    if (reqValid) begin
      strobe.active = 1'b1;
      unique case (addrMode_e'(addrMode))
        AM_DIRECT: begin
          if (isCg) begin
            strobe.useConst = 1'b1;
            strobe.constSel = K_ZERO;
          end else begin
            strobe.regDirect = 1'b1;
          end
        end
        AM_INDEXED: begin
          if (isCg) begin
            strobe.useConst = 1'b1;
            strobe.constSel = K_ONE;
          end else begin
            strobe.fetchExt = 1'b1;
            if (isSr) strobe.absAddr = 1'b1;
            else      strobe.addExt  = 1'b1;
          end
        end
        AM_INDIR: begin
          if (isSr) begin
            strobe.useConst = 1'b1;
            strobe.constSel = K_FOUR;
          end else if (isCg) begin
            strobe.useConst = 1'b1;
            strobe.constSel = K_TWO;
          end else begin
            strobe.regAddr = 1'b1;
          end
        end
        AM_POSTINC: begin
          if (isSr) begin
            strobe.useConst = 1'b1;
            strobe.constSel = K_EIGHT;
          end else if (isCg) begin
            strobe.useConst = 1'b1;
            strobe.constSel = K_ONES;
          end else begin
            strobe.regAddr  = 1'b1;
            strobe.postInc  = 1'b1;
            strobe.incByOne = byteOp && !isPc;
          end
        end
        default: strobe.active = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/opr_dpath.sv
module opr_dpath
  import opr_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned NUM_REGS     = 16,
  parameter int unsigned REG_IDX_W    = 4,
  parameter int unsigned PERIPH_LIMIT = 32'h0000_0200
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  oprStrobe_t                 strobe,
  input  logic [REG_IDX_W-1:0]       regSel,
  input  logic [NUM_REGS*DATA_W-1:0] regFlat,
  input  logic [DATA_W-1:0]          extWord,
  output logic                       outValid,
  output logic [DATA_W-1:0]          effAddr,
  output logic [DATA_W-1:0]          hiAddr,
  output logic                       memRead,
  output logic                       periphAccess,
  output logic                       constValid,
  output logic                       dataValid,
  output logic [DATA_W-1:0]          dataOut,
  output logic [DATA_W-1:0]          extAddr,
  output logic                       pcWrEn,
  output logic [DATA_W-1:0]          pcNext,
  output logic                       incWrEn,
  output logic [REG_IDX_W-1:0]       incReg,
  output logic [DATA_W-1:0]          incValue
);

  localparam int unsigned BYTE_W    = 8;
  localparam logic [DATA_W-1:0] BYTE_MASK = DATA_W'({BYTE_W{1'b1}});
  localparam logic [DATA_W-1:0] WORD_ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] STEP_ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] STEP_TWO  = DATA_W'(2);

  // Unpack the register file snapshot
  logic [DATA_W-1:0] regArr [NUM_REGS];
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign regArr[g] = regFlat[g*DATA_W +: DATA_W];
  end

  logic [DATA_W-1:0] selVal;
  logic [DATA_W-1:0] pcVal;
  logic [DATA_W-1:0] constC;
  logic [DATA_W-1:0] addrC;
  logic [DATA_W-1:0] regOpC;
  logic [DATA_W-1:0] stepC;
  logic              memRdC;
  logic              periphC;

  assign selVal = regArr[regSel];
  assign pcVal  = regArr[REG_PC];

  always_comb begin
    unique case (strobe.constSel)
      K_ZERO:  constC = '0;
      K_ONE:   constC = DATA_W'(1);
      K_TWO:   constC = DATA_W'(2);
      K_FOUR:  constC = DATA_W'(4);
      K_EIGHT: constC = DATA_W'(8);
      K_ONES:  constC = strobe.byteMode ? BYTE_MASK : WORD_ONES;
      default: constC = '0;
    endcase
  end

  always_comb begin
    if (strobe.absAddr)     addrC = extWord;
    else if (strobe.addExt) addrC = selVal + extWord;
    else                    addrC = selVal;
  end

  assign regOpC  = strobe.byteMode ? (selVal & BYTE_MASK) : selVal;
  assign stepC   = strobe.incByOne ? STEP_ONE : STEP_TWO;
  assign memRdC  = strobe.active && (strobe.absAddr || strobe.addExt || strobe.regAddr);
  assign periphC = memRdC && (32'(addrC) < PERIPH_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid     <= 1'b0;
      effAddr      <= '0;
      hiAddr       <= '0;
      memRead      <= 1'b0;
      periphAccess <= 1'b0;
      constValid   <= 1'b0;
      dataValid    <= 1'b0;
      dataOut      <= '0;
      extAddr      <= '0;
      pcWrEn       <= 1'b0;
      pcNext       <= '0;
      incWrEn      <= 1'b0;
      incReg       <= '0;
      incValue     <= '0;
    end else begin
      outValid     <= strobe.active;
      memRead      <= memRdC;
      periphAccess <= periphC;
      constValid   <= strobe.active && strobe.useConst;
      dataValid    <= strobe.active && (strobe.useConst || strobe.regDirect);
      pcWrEn       <= strobe.active && strobe.fetchExt;
      incWrEn      <= strobe.active && strobe.postInc;
      if (strobe.active) begin
        effAddr  <= memRdC ? addrC : '0;
        hiAddr   <= memRdC ? (addrC + STEP_ONE) : '0;
        dataOut  <= strobe.useConst ? constC : (strobe.regDirect ? regOpC : '0);
        extAddr  <= pcVal;
        pcNext   <= pcVal + STEP_TWO;
        incReg   <= regSel;
        incValue <= selVal + stepC;
      end
    end
  end

endmodule

// File: rtl/opr_resolve.sv
module opr_resolve
  import opr_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned NUM_REGS     = 16,
  parameter int unsigned PERIPH_LIMIT = 32'h0000_0200,
  localparam int unsigned REG_IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reqValid,
  input  logic [1:0]                 addrMode,
  input  logic [REG_IDX_W-1:0]       regSel,
  input  logic                       byteOp,
  input  logic [NUM_REGS*DATA_W-1:0] regFlat,
  input  logic [DATA_W-1:0]          extWord,
  output logic                       outValid,
  output logic [DATA_W-1:0]          effAddr,
  output logic [DATA_W-1:0]          hiAddr,
  output logic                       memRead,
  output logic                       periphAccess,
  output logic                       constValid,
  output logic                       dataValid,
  output logic [DATA_W-1:0]          dataOut,
  output logic [DATA_W-1:0]          extAddr,
  output logic                       pcWrEn,
  output logic [DATA_W-1:0]          pcNext,
  output logic                       incWrEn,
  output logic [REG_IDX_W-1:0]       incReg,
  output logic [DATA_W-1:0]          incValue
);

  oprStrobe_t strobe;

  opr_ctrl #(
    .REG_IDX_W(REG_IDX_W)
  ) u_ctrl (
    .reqValid(reqValid),
    .addrMode(addrMode),
    .regSel  (regSel),
    .byteOp  (byteOp),
    .strobe  (strobe)
  );

  opr_dpath #(
    .DATA_W      (DATA_W),
    .NUM_REGS    (NUM_REGS),
    .REG_IDX_W   (REG_IDX_W),
    .PERIPH_LIMIT(PERIPH_LIMIT)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .regSel      (regSel),
    .regFlat     (regFlat),
    .extWord     (extWord),
    .outValid    (outValid),
    .effAddr     (effAddr),
    .hiAddr      (hiAddr),
    .memRead     (memRead),
    .periphAccess(periphAccess),
    .constValid  (constValid),
    .dataValid   (dataValid),
    .dataOut     (dataOut),
    .extAddr     (extAddr),
    .pcWrEn      (pcWrEn),
    .pcNext      (pcNext),
    .incWrEn     (incWrEn),
    .incReg      (incReg),
    .incValue    (incValue)
  );

endmodule

// File: rtl/opr_resolve_chk.sv
module opr_resolve_chk #(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned PERIPH_LIMIT = 32'h0000_0200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              outValid,
  input logic [DATA_W-1:0] effAddr,
  input logic [DATA_W-1:0] hiAddr,
  input logic              memRead,
  input logic              periphAccess,
  input logic              constValid,
  input logic              dataValid,
  input logic [DATA_W-1:0] extAddr,
  input logic              pcWrEn,
  input logic [DATA_W-1:0] pcNext,
  input logic              incWrEn,
  input logic [DATA_W-1:0] incValue
);

  // R10
  const_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(memRead && constValid));

  // R10
  const_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    constValid |-> dataValid && !memRead);

  // R8
  periph_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periphAccess == (memRead && (32'(effAddr) < PERIPH_LIMIT)));

  // R9
  hi_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memRead |-> hiAddr == DATA_W'(effAddr + DATA_W'(1)));

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcWrEn |-> memRead && pcNext == DATA_W'(extAddr + DATA_W'(2)));

  // R7
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    incWrEn |-> memRead && !pcWrEn &&
      (incValue == DATA_W'(effAddr + DATA_W'(1)) || incValue == DATA_W'(effAddr + DATA_W'(2))));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !outValid && !memRead && !constValid && !dataValid && !pcWrEn && !incWrEn);

  // R11
  strobe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memRead || dataValid) |-> outValid);

endmodule

bind opr_resolve opr_resolve_chk #(
  .DATA_W      (DATA_W),
  .PERIPH_LIMIT(PERIPH_LIMIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reqValid    (reqValid),
  .outValid    (outValid),
  .effAddr     (effAddr),
  .hiAddr      (hiAddr),
  .memRead     (memRead),
  .periphAccess(periphAccess),
  .constValid  (constValid),
  .dataValid   (dataValid),
  .extAddr     (extAddr),
  .pcWrEn      (pcWrEn),
  .pcNext      (pcNext),
  .incWrEn     (incWrEn),
  .incValue    (incValue)
);

// File: tb/test_opr_resolve.sv
module test_opr_resolve;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  addrMode = '0;
  logic [3:0]  regSel = '0;
  logic        byteOp = 1'b0;
  logic [15:0] extWord = '0;
  logic [15:0] rf [16];
  logic [255:0] regFlat;

  logic        outValid, memRead, periphAccess, constValid, dataValid, pcWrEn, incWrEn;
  logic [15:0] effAddr, hiAddr, dataOut, extAddr, pcNext, incValue;
  logic [3:0]  incReg;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < 16; g++) begin : g_pack
    assign regFlat[g*16 +: 16] = rf[g];
  end

  opr_resolve i_opr_resolve (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .addrMode(addrMode),
    .regSel(regSel), .byteOp(byteOp), .regFlat(regFlat), .extWord(extWord),
    .outValid(outValid), .effAddr(effAddr), .hiAddr(hiAddr), .memRead(memRead),
    .periphAccess(periphAccess), .constValid(constValid), .dataValid(dataValid),
    .dataOut(dataOut), .extAddr(extAddr), .pcWrEn(pcWrEn), .pcNext(pcNext),
    .incWrEn(incWrEn), .incReg(incReg), .incValue(incValue)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Expected values computed from the requirements
  logic        eMem, eConst, eDv, ePc, eInc;
  logic [15:0] eData, eAddr, eIncVal;

  task automatic model(input logic [1:0] m, input logic [3:0] r, input logic b, input logic [15:0] x);
    logic [15:0] v;
    v = rf[r];
    eMem = 0; eConst = 0; eDv = 0; ePc = 0; eInc = 0;
    eData = 0; eAddr = 0; eIncVal = 0;
    case (m)
      2'd0: if (r == 3) begin eConst = 1; eData = 16'h0000; end
            else begin eDv = 1; eData = b ? (v & 16'h00FF) : v; end
      2'd1: if (r == 3) begin eConst = 1; eData = 16'h0001; end
            else begin eMem = 1; ePc = 1; eAddr = (r == 2) ? x : 16'(v + x); end
      2'd2: if (r == 2) begin eConst = 1; eData = 16'h0004; end
            else if (r == 3) begin eConst = 1; eData = 16'h0002; end
            else begin eMem = 1; eAddr = v; end
      default: if (r == 2) begin eConst = 1; eData = 16'h0008; end
            else if (r == 3) begin eConst = 1; eData = b ? 16'h00FF : 16'hFFFF; end
            else begin
              eMem = 1; eAddr = v; eInc = 1;
              eIncVal = 16'(v + ((b && r != 0) ? 16'd1 : 16'd2));
            end
    endcase
    if (eConst) eDv = 1;
  endtask

  task automatic run_op(input logic [1:0] m, input logic [3:0] r, input logic b, input logic [15:0] x);
    string mt;
    @(negedge clk);
    reqValid = 1'b1; addrMode = m; regSel = r; byteOp = b; extWord = x;
    model(m, r, b, x);
    @(posedge clk);
    #1;
    case (m)
      2'd0: mt = "R2";
      2'd1: mt = "R3";
      2'd2: mt = "R5";
      default: mt = "R6";
    endcase
    chk("R11", "outValid", 32'(outValid), 32'd1);
    chk("R10", "memRead", 32'(memRead), 32'(eMem));
    chk("R10", "constValid", 32'(constValid), 32'(eConst));
    chk(mt, "dataValid", 32'(dataValid), 32'(eDv));
    if (eDv) chk(mt, "dataOut", 32'(dataOut), 32'(eData));
    if (eMem) begin
      chk((m == 3) ? "R7" : mt, "effAddr", 32'(effAddr), 32'(eAddr));
      chk("R9", "hiAddr", 32'(hiAddr), 32'(16'(eAddr + 16'd1)));
    end
    chk("R8", "periphAccess", 32'(periphAccess), 32'(eMem && (eAddr < 16'h0200)));
    chk("R4", "pcWrEn", 32'(pcWrEn), 32'(ePc));
    if (ePc) begin
      chk("R4", "extAddr", 32'(extAddr), 32'(rf[0]));
      chk("R4", "pcNext", 32'(pcNext), 32'(16'(rf[0] + 16'd2)));
    end
    chk("R7", "incWrEn", 32'(incWrEn), 32'(eInc));
    if (eInc) begin
      chk("R7", "incValue", 32'(incValue), 32'(eIncVal));
      chk("R7", "incReg", 32'(incReg), 32'(r));
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk);
    #1;
    chk("R11", "idle outValid", 32'(outValid), 32'd0);
    chk("R11", "idle strobes", 32'({memRead, constValid, dataValid, pcWrEn, incWrEn}), 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd20240611);
    for (int i = 0; i < 16; i++) rf[i] = 16'(i * 16'h1111);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "reset strobes", 32'({outValid, memRead, constValid, dataValid, pcWrEn, incWrEn, periphAccess}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "first cycle strobes", 32'({outValid, memRead, constValid, dataValid, pcWrEn, incWrEn, periphAccess}), 32'd0);

    // Directed corner cases
    rf[0] = 16'hFFFE; rf[2] = 16'h1234; rf[4] = 16'hFFFF; rf[5] = 16'h01F0; rf[6] = 16'hFFF0;
    run_op(2'd0, 4'd3, 1'b0, 16'h5555);  // R2 constant 0
    run_op(2'd0, 4'd4, 1'b1, 16'h0000);  // R2 byte mask
    run_op(2'd1, 4'd3, 1'b0, 16'h7777);  // R3 constant 1
    run_op(2'd1, 4'd2, 1'b0, 16'h0150);  // R3 absolute, peripheral
    run_op(2'd1, 4'd6, 1'b0, 16'h0020);  // R3 wrap to 0x0010, R4 pc wrap
    run_op(2'd2, 4'd2, 1'b0, 16'h0000);  // R5 constant 4
    run_op(2'd2, 4'd3, 1'b1, 16'h0000);  // R5 constant 2
    run_op(2'd2, 4'd4, 1'b0, 16'h0000);  // R9 hi address wraps to 0
    run_op(2'd3, 4'd2, 1'b0, 16'h0000);  // R6 constant 8
    run_op(2'd3, 4'd3, 1'b1, 16'h0000);  // R6 ones byte
    run_op(2'd3, 4'd3, 1'b0, 16'h0000);  // R6 ones word
    run_op(2'd3, 4'd0, 1'b1, 16'h0000);  // R7 pc steps by 2 in byte mode
    run_op(2'd3, 4'd5, 1'b1, 16'h0000);  // R7 byte step 1
    run_op(2'd3, 4'd5, 1'b0, 16'h0000);  // R7 word step 2
    idle_check();

    // Constrained random
    for (int n = 0; n < 600; n++) begin
      for (int k = 0; k < 16; k++) begin
        case ($urandom_range(0, 3))
          0: rf[k] = 16'($urandom_range(0, 16'h03FF));
          1: rf[k] = 16'(16'hFFF0 + $urandom_range(0, 15));
          default: rf[k] = 16'($urandom);
        endcase
      end
      run_op(2'($urandom), 4'($urandom), 1'($urandom), 16'($urandom));
      if ((n % 37) == 0) idle_check();
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule